// File: doc/BRIEF.md
# Translation Cache Maintenance Controller

This block owns the maintenance side of the translation caches that sit in front of a page-table walker. There are three kinds: one small TLB per bus master, one larger TLB that all masters share, and a cache of walk results. Software drives the block through a small register port. It can queue whole-array flushes, invalidate TLB entries whose page number matches an address under a mask, and invalidate one walk-cache entry by exact page number. Each request bit reads back as 1 until its operation has been carried out, then clears itself, so software learns that an operation is done by polling.

The cache arrays are modelled inside the block as entries that each hold a valid bit and a tag. A refill port writes entries. A lookup port asks whether an array holds a tag. Pending operations are served one at a time, in a fixed priority order, and each takes a fixed number of cycles. The busy window can therefore be seen from outside. While any operation is pending, every lookup reports a miss.

Register map (word index on `wr_addr`/`rd_addr`): 0 flush request, 1 TLB invalidate address, 2 TLB invalidate mask, 3 TLB invalidate start (bit 0), 4 walk-cache invalidate address, 5 walk-cache invalidate start (bit 0). Address and mask registers hold a page number in bits [TAG_W-1:0].

Top module: `tlb_maint_ctrl`

## Requirements
- R1: After reset, every register reads 0, every array is empty and `lk_hit` is 0.
- R2: In the flush request register, bit k for k below NUM_MICRO selects per-master TLB k, bit 16 selects the shared TLB and bit 17 selects the walk cache. Writing 1 to a bit makes it pending and it reads back as 1. Writing 0 leaves it unchanged, and bits outside these positions are ignored and read 0. Any combination of bits may be set in one write.
- R3: Pending operations are served one at a time in this order: per-master TLB 0 up to the last one, the shared TLB, the walk cache, the TLB address invalidate, the walk-cache invalidate. Each operation finishes STEP+1 cycles after it starts and its request bit reads 0 from then on. A write setting N flush bits, with nothing else pending, leaves the register at 0 after the edge that falls 3N edges (STEP=2) after the write edge.
- R4: A completed flush clears every entry of its own array and no entry of any other array.
- R5: A TLB address invalidate clears, in every per-master and shared TLB entry, the entries whose tag equals the address in each bit where the mask is 1. It leaves other entries and the walk cache untouched. Its start bit reads 1 while pending and clears itself on completion. Writing 0 to the start bit has no effect.
- R6: A walk-cache invalidate clears only the walk-cache entries whose tag equals its address exactly, and its start bit clears itself on completion.
- R7: `lk_hit` is 1 in the cycle after `lk_en` exactly when nothing was pending and the array selected by `lk_sel` (0..NUM_MICRO-1 per-master, NUM_MICRO shared, NUM_MICRO+1 walk) holds a valid entry with tag `lk_tag`.
- R8: A refill writes the tag and sets the valid bit of entry `fill_idx` in array `fill_sel`. An index at or above that array's entry count is ignored.
- R9: `rd_data` shows the register at `rd_addr` one cycle later. Address and mask registers read back their low TAG_W bits, and indexes 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read index |
| rd_data | output | DATA_W | Registered read data |
| lk_en | input | 1 | Lookup request |
| lk_sel | input | SEL_W | Array selected for the lookup |
| lk_tag | input | TAG_W | Page number looked up |
| lk_hit | output | 1 | Registered lookup result |
| fill_en | input | 1 | Refill strobe |
| fill_sel | input | SEL_W | Array selected for the refill |
| fill_idx | input | IDX_W | Entry written by the refill |
| fill_tag | input | TAG_W | Tag written by the refill |

## Verification
A wrong sequencer state shows at the flush register within a few cycles. A bit that clears early, late or out of priority order changes the value read back in a particular cycle, so the bench compares that register on every cycle of a full eight-bit flush. A wrong match or wipe in an array only shows on a later lookup. The bench therefore looks up every entry of every array after each maintenance operation and compares the results against a model built from the masked-match rule. That exposes a stray kill or a surviving entry within one lookup per entry.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;
  // Flush register bit positions decoded by software.
  localparam int SHARED_FLUSH_BIT = 16;
  localparam int WALK_FLUSH_BIT   = 17;

  typedef enum logic [2:0] {
    RIDX_FLUSH     = 3'd0,
    RIDX_INV_ADDR  = 3'd1,
    RIDX_INV_MASK  = 3'd2,
    RIDX_INV_GO    = 3'd3,
    RIDX_WALK_ADDR = 3'd4,
    RIDX_WALK_GO   = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/tlb_tag_array.sv
module tlb_tag_array #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 3,
  parameter int TAG_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             wipe,
  input  logic             inv_en,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic [TAG_W-1:0] inv_mask,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_match
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] kill;
  logic [ENTRIES-1:0] hit;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    // Masked compare: a 0 in the mask makes that bit a don't-care.
    assign kill[e] = inv_en && (((tag_q[e] ^ inv_tag) & inv_mask) == '0);
    assign hit[e]  = valid_q[e] && (tag_q[e] == lk_tag);

    always_ff @(posedge clk) begin
      if (fill_en && fill_idx == IDX_W'(e)) tag_q[e] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (rst || wipe) begin
        valid_q[e] <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(e)) begin
        valid_q[e] <= 1'b1;
      end else if (kill[e]) begin
        valid_q[e] <= 1'b0;
      end
    end
  end

  assign lk_match = |hit;
endmodule

// File: rtl/tlb_op_seq.sv
module tlb_op_seq #(
  parameter int NOPS = 10,
  parameter int STEP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NOPS-1:0] pend,
  output logic [NOPS-1:0] done
);
  localparam int OP_W  = $clog2(NOPS);
  localparam int CNT_W = $clog2(STEP + 1);

  logic             active_q;
  logic [OP_W-1:0]  cur_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OP_W-1:0]  pick;
  logic             last;

  // Lowest pending index has priority.
  always_comb begin
    pick = '0;
    for (int k = NOPS - 1; k >= 0; k--) begin
      if (pend[k]) pick = OP_W'(k);
    end
  end

  assign last = active_q && (cnt_q == CNT_W'(STEP - 1));

  always_comb begin
    done = '0;
    if (last) done[cur_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cur_q    <= '0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (|pend) begin
        active_q <= 1'b1;
        cur_q    <= pick;
        cnt_q    <= '0;
      end
    end else if (last) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_maint_ctrl.sv
module tlb_maint_ctrl
  import tlb_maint_pkg::*;
#(
  parameter int NUM_MICRO     = 6,
  parameter int MICRO_ENTRIES = 4,
  parameter int SHARED_ENTRIES = 8,
  parameter int WALK_ENTRIES  = 4,
  parameter int TAG_W         = 20,
  parameter int DATA_W        = 32,
  parameter int STEP          = 2,
  localparam int NARR  = NUM_MICRO + 2,
  localparam int SEL_W = $clog2(NARR),
  localparam int MAXE  = (MICRO_ENTRIES > SHARED_ENTRIES) ?
                         ((MICRO_ENTRIES > WALK_ENTRIES) ? MICRO_ENTRIES : WALK_ENTRIES) :
                         ((SHARED_ENTRIES > WALK_ENTRIES) ? SHARED_ENTRIES : WALK_ENTRIES),
  localparam int IDX_W = $clog2(MAXE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lk_en,
  input  logic [SEL_W-1:0]  lk_sel,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  input  logic              fill_en,
  input  logic [SEL_W-1:0]  fill_sel,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag
);
  localparam int SHARED_IDX = NUM_MICRO;
  localparam int WALK_IDX   = NUM_MICRO + 1;
  localparam int OP_INV     = NARR;
  localparam int OP_WALK    = NARR + 1;
  localparam int NOPS       = NARR + 2;

  logic [NARR-1:0]  flush_pend;
  logic             inv_pend, walk_pend;
  logic [TAG_W-1:0] inv_addr_q, inv_mask_q, walk_addr_q;
  logic [NARR-1:0]  flush_set;
  logic [NOPS-1:0]  seq_done;
  logic             busy;
  logic [NARR-1:0]  lk_match;
  logic [(1<<SEL_W)-1:0] match_pad;
  logic [DATA_W-1:0] flush_view;
  logic             wr_flush, wr_ig, wr_wg;
  wire              unused_wdata = ^wr_data;

  assign wr_flush = wr_en && wr_addr == RIDX_FLUSH;
  assign wr_ig    = wr_en && wr_addr == RIDX_INV_GO && wr_data[0];
  assign wr_wg    = wr_en && wr_addr == RIDX_WALK_GO && wr_data[0];

  // Map register bit positions onto the compact per-array request vector.
  always_comb begin
    flush_set = '0;
    flush_view = '0;
    for (int k = 0; k < NUM_MICRO; k++) begin
      flush_set[k]  = wr_flush && wr_data[k];
      flush_view[k] = flush_pend[k];
    end
    flush_set[SHARED_IDX] = wr_flush && wr_data[SHARED_FLUSH_BIT];
    flush_set[WALK_IDX]   = wr_flush && wr_data[WALK_FLUSH_BIT];
    flush_view[SHARED_FLUSH_BIT] = flush_pend[SHARED_IDX];
    flush_view[WALK_FLUSH_BIT]   = flush_pend[WALK_IDX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_pend  <= '0;
      inv_pend    <= 1'b0;
      walk_pend   <= 1'b0;
      inv_addr_q  <= '0;
      inv_mask_q  <= '0;
      walk_addr_q <= '0;
    end else begin
      flush_pend <= (flush_pend & ~seq_done[NARR-1:0]) | flush_set;
      inv_pend   <= (inv_pend & ~seq_done[OP_INV]) | wr_ig;
      walk_pend  <= (walk_pend & ~seq_done[OP_WALK]) | wr_wg;
      if (wr_en && wr_addr == RIDX_INV_ADDR)  inv_addr_q  <= wr_data[TAG_W-1:0];
      if (wr_en && wr_addr == RIDX_INV_MASK)  inv_mask_q  <= wr_data[TAG_W-1:0];
      if (wr_en && wr_addr == RIDX_WALK_ADDR) walk_addr_q <= wr_data[TAG_W-1:0];
    end
  end

  assign busy = (|flush_pend) || inv_pend || walk_pend;

  tlb_op_seq #(.NOPS(NOPS), .STEP(STEP)) u_seq (
    .clk(clk), .rst(rst),
    .pend({walk_pend, inv_pend, flush_pend}),
    .done(seq_done)
  );

  for (genvar a = 0; a < NARR; a++) begin : g_arr
    localparam int ENT = (a < NUM_MICRO) ? MICRO_ENTRIES :
                         (a == SHARED_IDX) ? SHARED_ENTRIES : WALK_ENTRIES;
    localparam bit IS_WALK = (a == WALK_IDX);
    tlb_tag_array #(.ENTRIES(ENT), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
      .clk(clk), .rst(rst),
      .fill_en(fill_en && fill_sel == SEL_W'(a)),
      .fill_idx(fill_idx), .fill_tag(fill_tag),
      .wipe(seq_done[a]),
      .inv_en(IS_WALK ? seq_done[OP_WALK] : seq_done[OP_INV]),
      .inv_tag(IS_WALK ? walk_addr_q : inv_addr_q),
      .inv_mask(IS_WALK ? {TAG_W{1'b1}} : inv_mask_q),
      .lk_tag(lk_tag),
      .lk_match(lk_match[a])
    );
  end

  always_comb begin
    match_pad = '0;
    match_pad[NARR-1:0] = lk_match;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit  <= 1'b0;
      rd_data <= '0;
    end else begin
      lk_hit <= lk_en && !busy && match_pad[lk_sel];
      case (rd_addr)
        RIDX_FLUSH:     rd_data <= flush_view;
        RIDX_INV_ADDR:  rd_data <= DATA_W'(inv_addr_q);
        RIDX_INV_MASK:  rd_data <= DATA_W'(inv_mask_q);
        RIDX_INV_GO:    rd_data <= DATA_W'(inv_pend);
        RIDX_WALK_ADDR: rd_data <= DATA_W'(walk_addr_q);
        RIDX_WALK_GO:   rd_data <= DATA_W'(walk_pend);
        default:        rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tlb_maint_chk.sv
module tlb_maint_chk #(
  parameter int NARR = 8,
  parameter int NOPS = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [2:0]      wr_addr,
  input logic            lk_en,
  input logic            lk_hit,
  input logic            busy,
  input logic [NARR-1:0] flush_pend,
  input logic            inv_pend,
  input logic [NOPS-1:0] seq_done
);
  // R7: lookups during any pending operation miss.
  assert_pending_miss_R7: assert property (@(posedge clk) disable iff (rst)
    (lk_en && busy) |=> !lk_hit);

  // R2: a flush request only appears after a write to the flush register.
  assert_flush_set_by_write_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == 3'd0) |=> ((flush_pend & ~$past(flush_pend)) == '0));

  // R3: a flush request bit only drops when its operation completes.
  assert_flush_clear_on_done_R3: assert property (@(posedge clk) disable iff (rst)
    (seq_done[NARR-1:0] == '0) |=> (($past(flush_pend) & ~flush_pend) == '0));

  // R3: at most one operation completes per cycle.
  assert_single_done_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(seq_done));

  // R5: the invalidate start bit holds until its operation completes.
  assert_inv_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (inv_pend && !seq_done[NARR]) |=> inv_pend);
endmodule

bind tlb_maint_ctrl tlb_maint_chk #(.NARR(NARR), .NOPS(NOPS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .lk_en(lk_en), .lk_hit(lk_hit), .busy(busy),
  .flush_pend(flush_pend), .inv_pend(inv_pend), .seq_done(seq_done)
);

// File: tb/sim_tlb_maint_ctrl.sv
module sim_tlb_maint_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NM   = 6;
  localparam int NARR = NM + 2;
  localparam int STEP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        lk_en = 1'b0;
  logic [2:0]  lk_sel = '0;
  logic [19:0] lk_tag = '0;
  logic        lk_hit;
  logic        fill_en = 1'b0;
  logic [2:0]  fill_sel = '0;
  logic [2:0]  fill_idx = '0;
  logic [19:0] fill_tag = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit          mv [NARR][8];
  logic [19:0] mt [NARR][8];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_maint_ctrl #(.NUM_MICRO(NM), .MICRO_ENTRIES(4), .SHARED_ENTRIES(8),
                   .WALK_ENTRIES(4), .TAG_W(20), .DATA_W(32), .STEP(STEP)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lk_en(lk_en), .lk_sel(lk_sel),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .fill_en(fill_en), .fill_sel(fill_sel),
    .fill_idx(fill_idx), .fill_tag(fill_tag));

  function automatic int ent(int a);
    return (a < NM) ? 4 : (a == NM) ? 8 : 4;
  endfunction

  function automatic logic [19:0] tagv(int a, int i);
    return 20'h100 + 20'(a * 16 + i);
  endfunction

  function automatic int flush_pos(int k);
    return (k < NM) ? k : (k == NM) ? 16 : 17;
  endfunction

  function automatic bit model_hit(int a, logic [19:0] t);
    for (int i = 0; i < ent(a); i++) if (mv[a][i] && mt[a][i] == t) return 1;
    return 0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic lk(input int a, input logic [19:0] t, output logic h);
    lk_en = 1'b1; lk_sel = 3'(a); lk_tag = t;
    @(negedge clk);
    h = lk_hit; lk_en = 1'b0;
  endtask

  task automatic fl(input int a, input int i, input logic [19:0] t);
    fill_en = 1'b1; fill_sel = 3'(a); fill_idx = 3'(i); fill_tag = t;
    @(negedge clk);
    fill_en = 1'b0;
    if (i < ent(a)) begin mv[a][i] = 1; mt[a][i] = t; end
  endtask

  task automatic fill_all();
    for (int a = 0; a < NARR; a++)
      for (int i = 0; i < ent(a); i++) fl(a, i, tagv(a, i));
  endtask

  task automatic check_all(input string req);
    logic h;
    for (int a = 0; a < NARR; a++)
      for (int i = 0; i < ent(a); i++) begin
        lk(a, tagv(a, i), h);
        check(32'(h), 32'(model_hit(a, tagv(a, i))), req);
      end
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] f, g, w;
    for (int n = 0; n < 200; n++) begin
      rd(3'd0, f); rd(3'd3, g); rd(3'd5, w);
      if (f == 0 && g == 0 && w == 0) return;
    end
    check(32'hFFFF_FFFF, 32'h0, req);
  endtask

  task automatic addr_inv(input logic [19:0] ad, input logic [19:0] mk);
    logic [31:0] v;
    int n;
    fill_all();
    wr(3'd1, 32'(ad));
    wr(3'd2, 32'(mk));
    wr(3'd3, 32'h1);
    n = 1;
    // R5: start bit clears at the edge STEP+1 after the write edge; visible one read later.
    do begin rd(3'd3, v); n++; end while (v != 0 && n < 50);
    check(32'(n), 32'(STEP + 3), "R5 start bit self-clear timing");
    for (int a = 0; a < NM + 1; a++)
      for (int i = 0; i < ent(a); i++)
        if (((mt[a][i] ^ ad) & mk) == 0) mv[a][i] = 0;
    check_all("R5 masked invalidate");
  endtask

  initial begin
    logic [31:0] v;
    logic h;
    logic [31:0] full;
    for (int a = 0; a < NARR; a++) for (int i = 0; i < 8; i++) mv[a][i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int r = 0; r < 8; r++) begin rd(3'(r), v); check(v, 0, "R1 register reset"); end
    check(32'(lk_hit), 0, "R1 lk_hit reset");
    check_all("R1 arrays empty");

    // R8 / R7: refill and lookup
    fill_all();
    check_all("R8 refill then R7 lookup");
    fl(0, 5, 20'hABCDE);
    lk(0, 20'hABCDE, h);
    check(32'(h), 0, "R8 out of range index ignored");
    lk(1, tagv(0, 0), h);
    check(32'(h), 0, "R7 lookup other array misses");

    // R9: register readback
    wr(3'd1, 32'hFFFF_ABCD); rd(3'd1, v); check(v, 32'h000F_ABCD, "R9 inv address readback");
    wr(3'd2, 32'h0001_2345); rd(3'd2, v); check(v, 32'h0001_2345, "R9 inv mask readback");
    wr(3'd4, 32'h0007_7777); rd(3'd4, v); check(v, 32'h0007_7777, "R9 walk address readback");
    rd(3'd6, v); check(v, 0, "R9 unused index");
    rd(3'd7, v); check(v, 0, "R9 unused index");

    // R2: zero writes and unused bits have no effect
    wr(3'd0, 32'h0);
    rd(3'd0, v); check(v, 0, "R2 zero write");
    wr(3'd0, 32'h0000_FF00);
    rd(3'd0, v); check(v, 0, "R2 unused bits ignored");
    wr(3'd3, 32'h0);
    rd(3'd3, v); check(v, 0, "R5 zero start write ignored");
    check_all("R2 arrays untouched");

    // R4: single-array flush
    wr(3'd0, 32'h4);
    rd(3'd0, v); check(v, 32'h4, "R2 pending bit reads back");
    wait_idle("R4 flush never completed");
    for (int i = 0; i < 4; i++) mv[2][i] = 0;
    check_all("R4 only selected array flushed");

    // R3: all flush bits in one write, cycle-by-cycle order
    fill_all();
    full = 0;
    for (int k = 0; k < NARR; k++) full |= 32'h1 << flush_pos(k);
    wr(3'd0, full);
    for (int n = 2; n <= 3 * NARR + 3; n++) begin
      logic [31:0] e;
      int dn;
      rd(3'd0, v);
      dn = (n - 2) / 3;
      if (dn > NARR) dn = NARR;
      e = full;
      for (int k = 0; k < dn; k++) e &= ~(32'h1 << flush_pos(k));
      check(v, e, "R3 flush order and timing");
    end
    for (int a = 0; a < NARR; a++) for (int i = 0; i < 8; i++) mv[a][i] = 0;
    check_all("R4 full flush empties all");

    // R7: lookups during a pending operation miss
    fill_all();
    wr(3'd0, 32'h1_0000);
    lk(0, tagv(0, 0), h);
    check(32'(h), 0, "R7 miss while pending");
    wait_idle("R7 flush never completed");
    for (int i = 0; i < 8; i++) mv[NM][i] = 0;
    lk(0, tagv(0, 0), h);
    check(32'(h), 1, "R7 hit after completion");
    check_all("R4 shared array flush");

    // R5: masked address invalidate sweep
    addr_inv(20'h00120, 20'hFFFF0);
    addr_inv(20'h00101, 20'hFFF03);
    addr_inv(20'h00000, 20'h00000);
    addr_inv(20'h00167, 20'hFFFFF);

    // R6: walk-cache exact invalidate
    fill_all();
    fl(0, 0, tagv(NM + 1, 2));
    wr(3'd4, 32'(tagv(NM + 1, 2)));
    wr(3'd5, 32'h1);
    rd(3'd5, v); check(v, 1, "R6 start bit pending");
    wait_idle("R6 walk invalidate never completed");
    mv[NM + 1][2] = 0;
    check_all("R6 walk invalidate only walk cache");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R3 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule